// File: doc/BRIEF.md
# PFC Operating-State Supervisor

This block decides when a boost power-factor-correction stage may switch. It takes six single-bit comparator results: supply above its turn-on level, supply below its lockout level, line sense above its enable level, line sense below its brown-out level, feedback below its open-loop level, and feedback above its overvoltage level. From these it runs one ordered start-up and shutdown sequence through three states: OFF, STANDBY and RUN.

Each comparator flag passes through its own two-stage synchronizer before the state machine uses it. Three conditions have hysteresis: supply, line and feedback. OFF is left only when all enable conditions hold at once. A running converter drops to OFF when the supply falls below its lockout level. It drops to STANDBY on brown-out or open loop. Overvoltage never stops the converter. It raises a duty-reduce request, which follows the flag while RUN lasts. Every output is registered.

Top module: `pfc_state_supervisor`

## Requirements
- R1: After synchronous reset, state_code is 0 (OFF), gate_en is 0, fault_hold is 1 and duty_reduce is 0. The state codes are 0 = OFF, 1 = STANDBY and 2 = RUN, and code 3 never appears.
- R2: Every comparator flag takes effect exactly three clock edges after it is sampled: two synchronizer stages, then the state and output registers. A return from STANDBY to RUN adds no delay beyond this.
- R3: OFF moves to RUN only when all of these hold in the same cycle: supply above turn-on, supply not below lockout, line above enable, line not below brown-out, and feedback not below open loop. If the supply condition holds but any other does not, OFF moves to STANDBY.
- R4: Supply hysteresis. In STANDBY or RUN, the block returns to OFF only when the below-lockout flag is 1. The above-turn-on flag falling to 0 alone has no effect.
- R5: Line hysteresis. In RUN, a 1 on the brown-out flag moves the block to STANDBY. A line level between the two thresholds (both flags 0) changes nothing. Leaving STANDBY needs the enable flag at 1.
- R6: Open loop. In RUN, a 1 on the feedback-below-open-loop flag moves the block to STANDBY. The block returns to RUN once that flag is 0 and the line is enabled.
- R7: Priority. Supply lockout wins over brown-out and open loop, so the block goes to OFF and not STANDBY.
- R8: gate_en is 1 exactly when the state is RUN. fault_hold is its complement, so it is 1 in OFF and STANDBY, and this clamps the compensation nodes.
- R9: duty_reduce follows the overvoltage flag, with the R2 latency, while in RUN. It does not latch, it does not change state, and it is 0 outside RUN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vcc_above_on | input | 1 | Supply is above its turn-on threshold |
| vcc_below_off | input | 1 | Supply is below its lockout threshold |
| line_above_en | input | 1 | Line sense is above its enable threshold |
| line_below_bo | input | 1 | Line sense is below its brown-out threshold |
| fb_below_open | input | 1 | Feedback is below its open-loop threshold |
| fb_above_ovp | input | 1 | Feedback is above its overvoltage threshold |
| gate_en | output | 1 | Gate driver may switch |
| fault_hold | output | 1 | Fault/standby: clamp compensation nodes |
| duty_reduce | output | 1 | Request for reduced duty cycle (overvoltage) |
| state_code | output | 2 | 0 OFF, 1 STANDBY, 2 RUN |

## Verification
The assertions check on every cycle that:
- gate_en, fault_hold and state_code agree with each other, and code 3 never appears;
- every entry to RUN and every drop from RUN to STANDBY is backed by the flags sampled three edges earlier;
- a lockout flag always yields OFF;
- duty_reduce mirrors the delayed overvoltage flag only inside RUN.

Only the directed scenarios can show the behaviour of the hysteresis bands, because those depend on a flag returning to 0 and nothing happening. The scenarios also pin the exact edge at which STANDBY returns to RUN, and they show the priority order when faults coincide.

// File: rtl/pfc_sup_pkg.sv
package pfc_sup_pkg;

  typedef enum logic [1:0] {
    ST_OFF     = 2'd0,
    ST_STANDBY = 2'd1,
    ST_RUN     = 2'd2
  } op_state_t;

  localparam int FLAG_COUNT = 6;
  localparam int F_VCC_ON   = 0;
  localparam int F_VCC_LOW  = 1;
  localparam int F_LINE_HI  = 2;
  localparam int F_LINE_LO  = 3;
  localparam int F_FB_OPEN  = 4;
  localparam int F_FB_OVP   = 5;

  typedef struct packed {
    logic fb_ovp;
    logic fb_open;
    logic line_lo;
    logic line_hi;
    logic vcc_low;
    logic vcc_on;
  } flag_set_t;

endpackage

// File: rtl/pfc_flag_sync.sv
module pfc_flag_sync #(
  parameter int WIDTH  = 6,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  localparam int LAST = STAGES - 1;

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
      if (rst) chain <= '0;
      else     chain <= {chain[STAGES-2:0], async_in[b]};
    end

    assign sync_out[b] = chain[LAST];
  end

endmodule

// File: rtl/pfc_sup_fsm.sv
module pfc_sup_fsm
  import pfc_sup_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  flag_set_t flags,
  output op_state_t cur_state,
  output op_state_t nxt_state
);

  logic run_ok;

  // every enable condition at once (line and feedback side)
  assign run_ok = flags.line_hi && !flags.line_lo && !flags.fb_open;

  always_comb begin
    nxt_state = cur_state;
    unique case (cur_state)
      ST_OFF: begin
        if (flags.vcc_on && !flags.vcc_low)
          nxt_state = run_ok ? ST_RUN : ST_STANDBY;
      end
      ST_STANDBY: begin
        if (flags.vcc_low)  nxt_state = ST_OFF;      // lockout first
        else if (run_ok)    nxt_state = ST_RUN;
      end
      ST_RUN: begin
        if (flags.vcc_low)       nxt_state = ST_OFF;
        else if (flags.line_lo)  nxt_state = ST_STANDBY;
        else if (flags.fb_open)  nxt_state = ST_STANDBY;
      end
      default: nxt_state = ST_OFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) cur_state <= ST_OFF;
    else     cur_state <= nxt_state;
  end

endmodule

// File: rtl/pfc_sup_outreg.sv
module pfc_sup_outreg
  import pfc_sup_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  op_state_t  nxt_state,
  input  logic       ovp_flag,
  output logic       gate_en,
  output logic       fault_hold,
  output logic       duty_reduce,
  output logic [1:0] state_code
);

  logic will_run;
  assign will_run = (nxt_state == ST_RUN);

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_en     <= 1'b0;
      fault_hold  <= 1'b1;
      duty_reduce <= 1'b0;
      state_code  <= ST_OFF;
    end else begin
      gate_en     <= will_run;
      fault_hold  <= !will_run;
      duty_reduce <= will_run && ovp_flag;
      state_code  <= nxt_state;
    end
  end

endmodule

// File: rtl/pfc_state_supervisor.sv
module pfc_state_supervisor
  import pfc_sup_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       vcc_above_on,
  input  logic       vcc_below_off,
  input  logic       line_above_en,
  input  logic       line_below_bo,
  input  logic       fb_below_open,
  input  logic       fb_above_ovp,
  output logic       gate_en,
  output logic       fault_hold,
  output logic       duty_reduce,
  output logic [1:0] state_code
);

  logic [FLAG_COUNT-1:0] raw_flags;
  logic [FLAG_COUNT-1:0] clean_flags;
  flag_set_t             flags;
  op_state_t             cur_state;
  op_state_t             nxt_state;

  always_comb begin
    raw_flags            = '0;
    raw_flags[F_VCC_ON]  = vcc_above_on;
    raw_flags[F_VCC_LOW] = vcc_below_off;
    raw_flags[F_LINE_HI] = line_above_en;
    raw_flags[F_LINE_LO] = line_below_bo;
    raw_flags[F_FB_OPEN] = fb_below_open;
    raw_flags[F_FB_OVP]  = fb_above_ovp;
  end

  pfc_flag_sync #(
    .WIDTH  (FLAG_COUNT),
    .STAGES (SYNC_STAGES)
  ) sync_i (
    .clk      (clk),
    .rst      (rst),
    .async_in (raw_flags),
    .sync_out (clean_flags)
  );

  always_comb begin
    flags.vcc_on  = clean_flags[F_VCC_ON];
    flags.vcc_low = clean_flags[F_VCC_LOW];
    flags.line_hi = clean_flags[F_LINE_HI];
    flags.line_lo = clean_flags[F_LINE_LO];
    flags.fb_open = clean_flags[F_FB_OPEN];
    flags.fb_ovp  = clean_flags[F_FB_OVP];
  end

  pfc_sup_fsm fsm_i (
    .clk       (clk),
    .rst       (rst),
    .flags     (flags),
    .cur_state (cur_state),
    .nxt_state (nxt_state)
  );

  pfc_sup_outreg out_i (
    .clk         (clk),
    .rst         (rst),
    .nxt_state   (nxt_state),
    .ovp_flag    (flags.fb_ovp),
    .gate_en     (gate_en),
    .fault_hold  (fault_hold),
    .duty_reduce (duty_reduce),
    .state_code  (state_code)
  );

endmodule

// File: rtl/pfc_sup_checker.sv
module pfc_sup_checker (
  input logic       clk,
  input logic       rst,
  input logic       vcc_above_on,
  input logic       vcc_below_off,
  input logic       line_above_en,
  input logic       line_below_bo,
  input logic       fb_below_open,
  input logic       fb_above_ovp,
  input logic       gate_en,
  input logic       fault_hold,
  input logic       duty_reduce,
  input logic [1:0] state_code
);

  // R1: code 3 is never produced
  a_r1_code_legal: assert property (@(posedge clk) disable iff (rst)
    state_code != 2'd3);

  // R8: gate enable matches RUN, fault is its complement
  a_r8_gate_run: assert property (@(posedge clk) disable iff (rst)
    gate_en == (state_code == 2'd2));
  a_r8_fault_compl: assert property (@(posedge clk) disable iff (rst)
    fault_hold == !gate_en);

  // R3: entry to RUN backed by flags sampled three edges earlier
  a_r3_run_entry: assert property (@(posedge clk) disable iff (rst)
    (state_code == 2'd2 && $past(state_code) != 2'd2) |->
      (!$past(vcc_below_off, 3) && $past(line_above_en, 3) &&
       !$past(line_below_bo, 3) && !$past(fb_below_open, 3)));

  // R4/R7: a lockout flag always gives OFF
  a_r7_lockout_off: assert property (@(posedge clk) disable iff (rst)
    $past(vcc_below_off, 3) |-> state_code == 2'd0);

  // R5/R6: leaving RUN for STANDBY needs brown-out or open loop
  a_r6_standby_cause: assert property (@(posedge clk) disable iff (rst)
    (state_code == 2'd1 && $past(state_code) == 2'd2) |->
      ($past(line_below_bo, 3) || $past(fb_below_open, 3)));

  // R9: duty reduce mirrors delayed overvoltage flag in RUN only
  a_r9_ovp_follow: assert property (@(posedge clk) disable iff (rst)
    state_code == 2'd2 |-> duty_reduce == $past(fb_above_ovp, 3));
  a_r9_ovp_idle: assert property (@(posedge clk) disable iff (rst)
    state_code != 2'd2 |-> !duty_reduce);

endmodule

bind pfc_state_supervisor pfc_sup_checker chk_i (
  .clk           (clk),
  .rst           (rst),
  .vcc_above_on  (vcc_above_on),
  .vcc_below_off (vcc_below_off),
  .line_above_en (line_above_en),
  .line_below_bo (line_below_bo),
  .fb_below_open (fb_below_open),
  .fb_above_ovp  (fb_above_ovp),
  .gate_en       (gate_en),
  .fault_hold    (fault_hold),
  .duty_reduce   (duty_reduce),
  .state_code    (state_code)
);

// File: tb/pfc_state_supervisor_tb.sv
module pfc_state_supervisor_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       vcc_above_on = 1'b0, vcc_below_off = 1'b1;
  logic       line_above_en = 1'b0, line_below_bo = 1'b1;
  logic       fb_below_open = 1'b1, fb_above_ovp = 1'b0;
  logic       gate_en, fault_hold, duty_reduce;
  logic [1:0] state_code;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  localparam logic [1:0] C_OFF = 2'd0, C_SBY = 2'd1, C_RUN = 2'd2;

  always #2 clk = ~clk;   // 250 MHz

  pfc_state_supervisor dut_i (.*);

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // check code plus gate/fault consistency
  task automatic check_state(input string req, input logic [1:0] exp);
    check(req, state_code, exp);
    check({req, " gate"}, gate_en, exp == C_RUN);
    check({req, " fault"}, fault_hold, exp != C_RUN);
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_flags(input logic von, input logic vlow, input logic lhi,
                           input logic llo, input logic fopen, input logic fovp);
    vcc_above_on = von; vcc_below_off = vlow; line_above_en = lhi;
    line_below_bo = llo; fb_below_open = fopen; fb_above_ovp = fovp;
  endtask

  // healthy run conditions, from any state, settle 4 cycles
  task automatic go_run();
    set_flags(1, 0, 1, 0, 0, 0);
    step(4);
  endtask

  task automatic power_down();
    set_flags(0, 1, 0, 1, 1, 0);
    step(4);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    set_flags(1, 0, 1, 0, 0, 1);
    step(3);
    check_state("R1 reset", C_OFF);
    check("R1 reset duty", duty_reduce, 0);
    rst = 1'b0;
    step(1);
    check("R2 one edge after reset still OFF", state_code, C_OFF);
    step(3);
    check_state("R3 start with all conditions", C_RUN);
    power_down();
  endtask

  task automatic t_start_blocked();
    set_flags(1, 0, 0, 0, 0, 0);     // line between thresholds
    step(4);
    check_state("R3 line not enabled -> STANDBY", C_SBY);
    set_flags(1, 0, 1, 0, 1, 0);     // open loop
    step(4);
    check_state("R6 open loop holds STANDBY", C_SBY);
    set_flags(1, 0, 1, 0, 0, 0);
    step(4);
    check_state("R6 open loop cleared -> RUN", C_RUN);
    power_down();
  endtask

  task automatic t_supply_hyst();
    go_run();
    set_flags(0, 0, 1, 0, 0, 0);     // between supply thresholds
    step(6);
    check_state("R4 supply in band keeps RUN", C_RUN);
    set_flags(0, 1, 1, 0, 0, 0);
    step(4);
    check_state("R4 lockout -> OFF", C_OFF);
    set_flags(0, 0, 1, 0, 0, 0);     // in band from OFF
    step(4);
    check_state("R4 in band does not start", C_OFF);
    power_down();
  endtask

  task automatic t_brownout();
    go_run();
    set_flags(1, 0, 0, 0, 0, 0);
    step(5);
    check_state("R5 line in band keeps RUN", C_RUN);
    set_flags(1, 0, 0, 1, 0, 0);
    step(4);
    check_state("R5 brown-out -> STANDBY", C_SBY);
    set_flags(1, 0, 0, 0, 0, 0);
    step(5);
    check_state("R5 line in band stays STANDBY", C_SBY);
    // R2: return from STANDBY takes exactly three edges
    set_flags(1, 0, 1, 0, 0, 0);
    step(2);
    check("R2 two edges still STANDBY", state_code, C_SBY);
    step(1);
    check_state("R2 third edge RUN", C_RUN);
    power_down();
  endtask

  task automatic t_open_loop();
    go_run();
    set_flags(1, 0, 1, 0, 1, 0);
    step(4);
    check_state("R6 open loop -> STANDBY", C_SBY);
    power_down();
  endtask

  task automatic t_priority();
    go_run();
    set_flags(1, 1, 0, 1, 1, 0);
    step(4);
    check_state("R7 lockout wins -> OFF", C_OFF);
    power_down();
  endtask

  task automatic t_ovp();
    go_run();
    set_flags(1, 0, 1, 0, 0, 1);
    step(2);
    check("R9 ovp not yet", duty_reduce, 0);
    step(1);
    check("R9 ovp request", duty_reduce, 1);
    check_state("R9 ovp keeps RUN", C_RUN);
    set_flags(1, 0, 1, 0, 0, 0);
    step(3);
    check("R9 ovp non-latching", duty_reduce, 0);
    set_flags(1, 0, 0, 1, 0, 1);     // brown-out with ovp
    step(4);
    check("R9 no request outside RUN", duty_reduce, 0);
    check_state("R9 brown-out still STANDBY", C_SBY);
    power_down();
  endtask

  initial begin
    step(1);
    t_reset();
    t_start_blocked();
    t_supply_hyst();
    t_brownout();
    t_open_loop();
    t_priority();
    t_ovp();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule